// File: doc/BRIEF.md
# Configuration Completion Ordering Gate

This block sits on the completion return path of an eight-entry transaction table. When the table allocates an entry it also records whether the access is a configuration access issued by the host processor. Both memory-mapped and port-I/O configuration accesses count. While any internal message-signalled interrupt (MSI) is still pending, completions for those marked entries are held back. A configuration read from the processor therefore cannot return before the interrupts raised ahead of it have become visible, and software can use such a read as a flush. Nothing else waits: every other completion keeps moving and overtakes the held ones.

Completion requests name a table index and carry their return data. Ready entries leave in the order their requests arrived. Entries that are currently held are skipped. The pending-MSI wires are ORed together and registered once, so a held completion is released one cycle after the last wire falls. The output is a registered valid/ready stage. Each accepted completion frees its entry, and the index of the freed entry is reported on a registered pulse in the cycle after acceptance.

Top module: `cfg_cpl_gate`

## Requirements
- R1: An entry is marked for holding exactly when, at allocation, `alloc_from_cpu`=1 and at least one of `alloc_cfg_mem` or `alloc_cfg_io` is 1. Either configuration style alone is enough.
- R2: An entry allocated with `alloc_from_cpu`=0 (inbound traffic) is never held, even when it is a configuration access of either style.
- R3: A marked entry is never presented on `cpl_valid` while any bit of `msi_pend` was high in the previous cycle. Each of the `msi_pend` bits holds it on its own.
- R4: While marked entries are held, unmarked entries still complete and overtake them.
- R5: Among entries that are allowed to leave, completions appear in the order their requests were accepted.
- R6: If the output stage is empty and the last high `msi_pend` bit falls before clock edge E1, a held completion appears on `cpl_valid` after edge E2 and not earlier. An unheld request sampled at edge E0 appears after E1.
- R7: While `cpl_valid`=1 and `cpl_ready`=0, `cpl_valid`, `cpl_idx` and `cpl_data` stay unchanged.
- R8: The cycle after a handshake (`cpl_valid` and `cpl_ready` both 1), `free_valid`=1 and `free_idx` equals the accepted index. In any other cycle `free_valid`=0.
- R9: `cpl_data` equals the `req_data` that was supplied with that entry's completion request.
- R10: After reset, `cpl_valid`=0 and `free_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate a table entry |
| alloc_idx | input | 3 | Entry being allocated |
| alloc_from_cpu | input | 1 | Access was issued by the host processor |
| alloc_cfg_mem | input | 1 | Memory-mapped configuration access |
| alloc_cfg_io | input | 1 | Port-I/O configuration access |
| msi_pend | input | 3 | Pending internal MSI wires, one per source |
| req_valid | input | 1 | Completion for an entry is ready to return |
| req_idx | input | 3 | Entry the completion belongs to |
| req_data | input | 16 | Completion data |
| cpl_valid | output | 1 | Gated completion valid |
| cpl_ready | input | 1 | Downstream accepts the completion |
| cpl_idx | output | 3 | Entry of the presented completion |
| cpl_data | output | 16 | Data of the presented completion |
| free_valid | output | 1 | Entry deallocated (one-cycle pulse) |
| free_idx | output | 3 | Entry being deallocated |

## Verification
An unheld completion request sampled at one edge reaches `cpl_valid` after the next edge. A released hold needs one more edge, because of the MSI register, and the deallocation pulse trails the handshake by one edge. Inputs are driven just after each falling edge. Outputs are read one nanosecond later, so every sample sees the settled result of the preceding rising edge. The sweep uses all 256 patterns of marked entries and rotates both the request order and the MSI source. During each pattern the bench first checks that only the unmarked entries complete while an MSI is pending, and in request order. It then checks that the marked ones follow in request order after release. Directed sequences check the exact release edge and the backpressure hold.

// File: rtl/cfg_gate_pkg.sv
package cfg_gate_pkg;
  localparam int unsigned ENTRIES_DEF = 8;
  localparam int unsigned MSI_DEF     = 3;
  localparam int unsigned DATA_DEF    = 16;

  function automatic logic hold_class(input logic from_cpu, input logic cfg_mem,
                                      input logic cfg_io);
    return from_cpu & (cfg_mem | cfg_io);
  endfunction
endpackage

// File: rtl/cfg_msi_sync.sv
module cfg_msi_sync #(
  parameter int unsigned MSI_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MSI_W-1:0] msi_pend,
  output logic             msi_any_q
);
  always_ff @(posedge clk) begin
    if (rst) msi_any_q <= 1'b0;
    else     msi_any_q <= |msi_pend;
  end
endmodule

// File: rtl/cfg_tag_table.sv
module cfg_tag_table #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc_v,
  input  logic [IW-1:0] alloc_idx,
  input  logic          alloc_tag,
  input  logic          req_v,
  input  logic [IW-1:0] req_idx,
  input  logic          issue_v,
  input  logic [IW-1:0] issue_idx,
  input  logic          free_v,
  input  logic [IW-1:0] free_idx,
  input  logic          hold,
  output logic [N-1:0]  tag,
  output logic [N-1:0]  rdy,
  output logic [N-1:0]  elig
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tag <= '0;
      rdy <= '0;
    end else begin
      if (free_v)  tag[free_idx]  <= 1'b0;
      if (alloc_v) tag[alloc_idx] <= alloc_tag;
      if (issue_v) rdy[issue_idx] <= 1'b0;
      if (req_v)   rdy[req_idx]   <= 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) elig[i] = rdy[i] & ~(tag[i] & hold);
  end

  // R2/R3: an entry that is held must not be offered for selection
  a_r3_held_not_eligible: assert property (@(posedge clk) disable iff (rst)
    (hold && |(tag & rdy)) |-> ((elig & tag) == '0));
endmodule

// File: rtl/cfg_age_pick.sv
module cfg_age_pick #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_v,
  input  logic [IW-1:0] push_idx,
  input  logic [N-1:0]  rdy,
  input  logic [N-1:0]  elig,
  output logic          grant_any,
  output logic [IW-1:0] grant_idx
);
  // older[j][i] = 1 : entry j became ready before entry i
  logic [N-1:0] older [N];
  logic [N-1:0] gnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < N; j++) older[j] <= '0;
    end else if (push_v) begin
      for (int j = 0; j < N; j++) begin
        if (IW'(j) != push_idx) older[j][push_idx] <= rdy[j];
        older[push_idx][j] <= 1'b0;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic blk;
      blk = 1'b0;
      for (int j = 0; j < N; j++)
        if (j != i) blk = blk | (elig[j] & older[j][i]);
      gnt[i] = elig[i] & ~blk;
    end
  end

  always_comb begin
    grant_idx = '0;
    for (int i = 0; i < N; i++)
      if (gnt[i]) grant_idx = IW'(i);
  end

  assign grant_any = |gnt;

  // R5: the oldest-first choice is unique
  a_r5_single_grant: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt));
  a_r5_grant_when_any: assert property (@(posedge clk) disable iff (rst)
    (|elig) |-> grant_any);
endmodule

// File: rtl/cfg_cpl_gate.sv
module cfg_cpl_gate #(
  parameter int unsigned ENTRIES = cfg_gate_pkg::ENTRIES_DEF,
  parameter int unsigned MSI_W   = cfg_gate_pkg::MSI_DEF,
  parameter int unsigned DATA_W  = cfg_gate_pkg::DATA_DEF,
  localparam int unsigned IW     = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_valid,
  input  logic [IW-1:0]     alloc_idx,
  input  logic              alloc_from_cpu,
  input  logic              alloc_cfg_mem,
  input  logic              alloc_cfg_io,
  input  logic [MSI_W-1:0]  msi_pend,
  input  logic              req_valid,
  input  logic [IW-1:0]     req_idx,
  input  logic [DATA_W-1:0] req_data,
  output logic              cpl_valid,
  input  logic              cpl_ready,
  output logic [IW-1:0]     cpl_idx,
  output logic [DATA_W-1:0] cpl_data,
  output logic              free_valid,
  output logic [IW-1:0]     free_idx
);
  logic              msi_any_q;
  logic [ENTRIES-1:0] tag, rdy, elig;
  logic              grant_any;
  logic [IW-1:0]     grant_idx;
  logic              slot_open, load, hs;
  logic [DATA_W-1:0] data_mem [ENTRIES];

  assign slot_open = ~cpl_valid | cpl_ready;
  assign load      = slot_open & grant_any;
  assign hs        = cpl_valid & cpl_ready;

  cfg_msi_sync #(.MSI_W(MSI_W)) u_msi (
    .clk(clk), .rst(rst), .msi_pend(msi_pend), .msi_any_q(msi_any_q)
  );

  cfg_tag_table #(.N(ENTRIES), .IW(IW)) u_tbl (
    .clk(clk), .rst(rst),
    .alloc_v(alloc_valid), .alloc_idx(alloc_idx),
    .alloc_tag(cfg_gate_pkg::hold_class(alloc_from_cpu, alloc_cfg_mem, alloc_cfg_io)),
    .req_v(req_valid), .req_idx(req_idx),
    .issue_v(load), .issue_idx(grant_idx),
    .free_v(hs), .free_idx(cpl_idx),
    .hold(msi_any_q),
    .tag(tag), .rdy(rdy), .elig(elig)
  );

  cfg_age_pick #(.N(ENTRIES), .IW(IW)) u_pick (
    .clk(clk), .rst(rst),
    .push_v(req_valid), .push_idx(req_idx),
    .rdy(rdy), .elig(elig),
    .grant_any(grant_any), .grant_idx(grant_idx)
  );

  // completion data store, no reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (req_valid) data_mem[req_idx] <= req_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpl_valid <= 1'b0;
      cpl_idx   <= '0;
      cpl_data  <= '0;
    end else if (slot_open) begin
      cpl_valid <= grant_any;
      if (grant_any) begin
        cpl_idx  <= grant_idx;
        cpl_data <= data_mem[grant_idx];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      free_valid <= 1'b0;
      free_idx   <= '0;
    end else begin
      free_valid <= hs;
      free_idx   <= cpl_idx;
    end
  end

  a_r3_no_release_under_msi: assert property (@(posedge clk) disable iff (rst)
    (load && tag[grant_idx]) |-> !$past(|msi_pend));
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (cpl_valid && !cpl_ready) |=> (cpl_valid && $stable(cpl_idx) && $stable(cpl_data)));
  a_r8_free_follows: assert property (@(posedge clk) disable iff (rst)
    hs |=> (free_valid && free_idx == $past(cpl_idx)));
  a_r8_free_only_after_hs: assert property (@(posedge clk) disable iff (rst)
    !hs |=> !free_valid);
  a_r10_reset_idle: assert property (@(posedge clk) rst |=> (!cpl_valid && !free_valid));
endmodule

// File: tb/cfg_cpl_gate_tb.sv
module cfg_cpl_gate_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        alloc_valid = 0, alloc_from_cpu = 0, alloc_cfg_mem = 0, alloc_cfg_io = 0;
  logic [2:0]  alloc_idx = 0;
  logic [2:0]  msi_pend = 0;
  logic        req_valid = 0;
  logic [2:0]  req_idx = 0;
  logic [15:0] req_data = 0;
  logic        cpl_valid, cpl_ready = 1'b1;
  logic [2:0]  cpl_idx, free_idx;
  logic [15:0] cpl_data;
  logic        free_valid;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  int obs_idx [0:15];
  int obs_n = 0;
  int cur_m = 0;
  logic [15:0] exp_data [0:7];
  logic prev_hs = 0;
  logic [2:0] prev_idx = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cfg_cpl_gate u_dut (
    .clk(clk), .rst(rst),
    .alloc_valid(alloc_valid), .alloc_idx(alloc_idx), .alloc_from_cpu(alloc_from_cpu),
    .alloc_cfg_mem(alloc_cfg_mem), .alloc_cfg_io(alloc_cfg_io),
    .msi_pend(msi_pend),
    .req_valid(req_valid), .req_idx(req_idx), .req_data(req_data),
    .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_idx(cpl_idx), .cpl_data(cpl_data),
    .free_valid(free_valid), .free_idx(free_idx)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (pattern %0d, t=%0t)", req, act, expv, cur_m, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // monitor: 1 ns after the falling edge, well clear of the rising edge
  always @(negedge clk) begin
    #1;
    cycles++;
    if (!rst) begin
      // R8: deallocation pulse trails the handshake by one edge
      if (prev_hs) check(free_valid && free_idx == prev_idx, "R8", free_idx, prev_idx);
      else         check(!free_valid, "R8", free_valid, 0);
      if (cpl_valid && cpl_ready) begin
        if (obs_n < 16) obs_idx[obs_n] = cpl_idx;
        obs_n++;
        check(cpl_data == exp_data[cpl_idx], "R9", cpl_data, exp_data[cpl_idx]);
      end
      prev_hs  = cpl_valid && cpl_ready;
      prev_idx = cpl_idx;
    end
  end

  initial begin
    while (cycles < 150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
    finish_run();
  end

  task automatic do_alloc(input int idx, input bit cpu, input bit mem, input bit io);
    @(negedge clk);
    alloc_valid = 1; alloc_idx = 3'(idx);
    alloc_from_cpu = cpu; alloc_cfg_mem = mem; alloc_cfg_io = io;
    @(negedge clk);
    alloc_valid = 0;
  endtask

  task automatic do_req(input int idx, input logic [15:0] d);
    @(negedge clk);
    exp_data[idx] = d;
    req_valid = 1; req_idx = 3'(idx); req_data = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) exp_data[i] = 0;
    idle(3);
    @(negedge clk); rst = 0;
    #1;
    // R10
    check(!cpl_valid, "R10", cpl_valid, 0);
    check(!free_valid, "R10", free_valid, 0);

    // sweep of every marked-entry pattern
    for (int m = 0; m < 256; m++) begin
      int order [0:7];
      int expo [0:7];
      int ne, nu;
      cur_m = m;
      obs_n = 0;
      @(negedge clk);
      msi_pend = 3'b001 << (m % 3);              // R3: each source alone holds
      for (int i = 0; i < 8; i++) begin
        if (m[i]) do_alloc(i, 1, i[0], !i[0]);   // R1: either style marks
        else case ((i + m) % 3)
          0: do_alloc(i, 1, 0, 0);               // processor, not configuration
          1: do_alloc(i, 0, 1, 0);               // R2: inbound memory-mapped
          default: do_alloc(i, 0, 0, 1);         // R2: inbound port-I/O
        endcase
      end
      for (int k = 0; k < 8; k++) order[k] = (k * 3 + m) % 8;
      ne = 0;
      for (int k = 0; k < 8; k++) if (!m[order[k]]) begin expo[ne] = order[k]; ne++; end
      nu = ne;
      for (int k = 0; k < 8; k++) if (m[order[k]]) begin expo[ne] = order[k]; ne++; end
      for (int k = 0; k < 8; k++) do_req(order[k], 16'(m * 8 + order[k]));
      idle(6);
      // R3/R4: only unmarked entries have left
      check(obs_n == nu, "R4", obs_n, nu);
      for (int k = 0; k < nu && k < obs_n; k++)
        check(obs_idx[k] == expo[k], "R5", obs_idx[k], expo[k]);
      @(negedge clk);
      msi_pend = 0;
      idle(12);
      check(obs_n == 8, "R3", obs_n, 8);
      for (int k = nu; k < 8 && k < obs_n; k++)
        check(obs_idx[k] == expo[k], "R5", obs_idx[k], expo[k]);
    end

    // R6: exact release edge, two sources
    cur_m = 300;
    obs_n = 0;
    @(negedge clk); msi_pend = 3'b101;
    do_alloc(3, 1, 1, 1);
    do_req(3, 16'hBEEF);
    idle(3);
    #1; check(!cpl_valid, "R3", cpl_valid, 0);
    @(negedge clk); msi_pend = 3'b100;            // one source still high
    idle(3);
    #1; check(!cpl_valid, "R3", cpl_valid, 0);
    @(negedge clk); msi_pend = 3'b000;            // falls before edge E1
    @(negedge clk); #1;                            // after E1
    check(!cpl_valid, "R6", cpl_valid, 0);
    @(negedge clk); #1;                            // after E2
    check(cpl_valid && cpl_idx == 3, "R6", cpl_idx, 3);
    idle(3);

    // R6 unheld latency and R7 backpressure
    cur_m = 301;
    obs_n = 0;
    @(negedge clk); cpl_ready = 0;
    do_alloc(1, 0, 1, 0);
    do_alloc(2, 1, 0, 0);
    @(negedge clk);
    exp_data[1] = 16'h1111;
    req_valid = 1; req_idx = 1; req_data = 16'h1111;   // sampled at E0
    @(negedge clk); req_valid = 0;                     // E0 passed
    #1; check(!cpl_valid, "R6", cpl_valid, 0);
    @(negedge clk); #1;                                // after E1
    check(cpl_valid && cpl_idx == 1, "R6", cpl_idx, 1);
    do_req(2, 16'h2222);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      check(cpl_valid && cpl_idx == 1 && cpl_data == 16'h1111, "R7", cpl_data, 16'h1111);
    end
    @(negedge clk); cpl_ready = 1;
    idle(4);
    check(obs_n == 2, "R5", obs_n, 2);
    if (obs_n >= 2) check(obs_idx[0] == 1 && obs_idx[1] == 2, "R5", obs_idx[1], 2);
    idle(2);
    finish_run();
  end
endmodule